// File: doc/BRIEF.md
# Two-Level Header Serial Packet Receiver

This block is the receiving end of a slave on a shared serial link: a serial clock, one active-low select line that several slaves share, and a data lane whose width is a build parameter. It rebuilds bytes from the lane and decodes a packet whose first byte carries a short function code. The function code decides what follows it. That can be a slave identifier, a burst length and a short or long address, in a layout that changes with the function. After the header come the payload bytes, which the block hands to a local register port. Each byte goes out as an address, a data byte and a one-cycle write strobe.

Read packets and mastership-transfer packets carry no payload into this block. For those it raises a single request pulse that the local logic acts on. A slave whose identifier does not match, and any reserved function code, leave the block silent until the select line is released. Releasing select at any point drops the packet and returns the parser to its start.

The serial clock, select and lane are sampled by the system clock through two-stage synchronizers. Rising serial-clock edges are found by edge detection. Each rising edge needs the serial clock to stay high and low for at least two system clocks.

Top module: `hls_rx`

## Requirements
- R1: After reset, `wr_stb`, `rd_stb` and `pass_stb` are low and `reg_addr` is zero.
- R2: A byte is built from 8/LANE_W rising serial-clock edges while select is low (LANE_W is 1, 2, 4 or 8). The first lane sample supplies the most significant bits, and lane bit LANE_W-1 is the more significant bit within a sample.
- R3: The function code is bits [7:5] of the first byte, and the other bits of that byte are ignored. Code 000 (single write) is followed by an identifier byte, one address byte and one data byte. It produces one write to the zero-extended address.
- R4: Code 001 (burst write) is followed by an identifier byte, a length byte L and one address byte. It produces L+1 writes at consecutive addresses starting from the zero-extended address, so a carry goes into bit 8.
- R5: Code 100 (broadcast write) has no identifier byte. It is followed by a length byte L and two address bytes (high byte first), then L+1 writes at consecutive addresses, whatever `my_id` is.
- R6: The identifier is bits [3:0] of the identifier byte. For codes 000 to 011 it matches when it equals `my_id` or is 1111. A slave that does not match produces no strobe of any kind until select is released.
- R7: Code 010 (single read) takes an identifier and one address byte, and code 011 (burst read) takes an identifier, a length L and one address byte. On a match, either one gives exactly one `rd_stb` with `reg_addr` set to the address and `rd_cnt` set to 1 or L+1. No write follows, even if more bytes arrive.
- R8: Code 101 (mastership transfer) takes an identifier byte and pulses `pass_stb` once, but only when the identifier equals `my_id` exactly. The value 1111 does not trigger it.
- R9: Codes 110 and 111 are reserved. Every byte after them is ignored until select is released, and the next packet then decodes normally.
- R10: Releasing select in the middle of a packet returns the parser to its start. A partly received byte is dropped without being written, and the next packet starts again at its function code byte.
- R11: `wr_stb` is high for exactly one system clock per payload byte. Bytes beyond the L+1 of a burst are ignored, and no two strobes are high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock; lane sampled on its rising edge |
| spi_sel_n | input | 1 | Shared select, active low |
| spi_lane | input | LANE_W | Serial data lane |
| my_id | input | 4 | This slave's identifier |
| wr_stb | output | 1 | One-cycle write strobe per payload byte |
| wr_data | output | 8 | Payload byte for the write |
| reg_addr | output | 16 | Address for the write or read request |
| rd_stb | output | 1 | One-cycle read request pulse |
| rd_cnt | output | 9 | Number of bytes requested by the read |
| pass_stb | output | 1 | One-cycle mastership-transfer pulse |

## Verification
The hardest case to reach is a select release that lands between lane samples of a byte inside a burst. The beat counter is then part way through while the parser sits in its payload state. The stimulus reaches it by sending two whole payload bytes and then only half the samples of a third before releasing select. A single write follows straight away, and the bench checks that exactly that one write appears, with no remains of the dropped byte. The identifier sweep covers all sixteen identifier values against a fixed `my_id`, which exercises both the exact match and the all-ones broadcast match.

// File: rtl/hls_pkg.sv
package hls_pkg;

    localparam int ADDR_W = 16;
    localparam int ID_W   = 4;
    localparam int LEN_W  = 9;

    localparam logic [2:0] FN_WR1  = 3'b000;
    localparam logic [2:0] FN_WRB  = 3'b001;
    localparam logic [2:0] FN_RD1  = 3'b010;
    localparam logic [2:0] FN_RDB  = 3'b011;
    localparam logic [2:0] FN_BCW  = 3'b100;
    localparam logic [2:0] FN_PASS = 3'b101;

    localparam logic [ID_W-1:0] ID_ALL = '1;

    typedef enum logic [2:0] {
        ST_CODE, ST_ID, ST_LEN, ST_AHI, ST_ALO, ST_DATA, ST_SKIP
    } pst_e;

    typedef struct packed {
        logic       vld;
        logic [7:0] val;
    } byte_ev_t;

    function automatic logic fn_writes(input logic [2:0] f);
        return (f == FN_WR1) || (f == FN_WRB) || (f == FN_BCW);
    endfunction

    function automatic logic fn_has_len(input logic [2:0] f);
        return (f == FN_WRB) || (f == FN_RDB) || (f == FN_BCW);
    endfunction

    function automatic logic id_hit(input logic [ID_W-1:0] got,
                                    input logic [ID_W-1:0] mine,
                                    input logic            exact);
        return (got == mine) || (!exact && got == ID_ALL);
    endfunction

endpackage

// File: rtl/hls_frontend.sv
module hls_frontend
    import hls_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sclk,
    input  logic              sel_n,
    input  logic [LANE_W-1:0] lane,
    output byte_ev_t          ev,
    output logic              active
);
    localparam int BEATS = 8 / LANE_W;
    localparam int CNT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

    logic [2:0]        s_clk;
    logic [1:0]        s_sel;
    logic [LANE_W-1:0] s_dat0, s_dat1;
    logic [CNT_W-1:0]  cnt;
    logic [7:0]        sh, nxt;
    logic              rise, sel_live;

    assign rise     = s_clk[1] & ~s_clk[2];
    assign sel_live = ~s_sel[1];

    generate
        if (LANE_W == 8) begin : g_full
            assign nxt = s_dat1;
        end else begin : g_part
            assign nxt = {sh[7-LANE_W:0], s_dat1};
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            s_clk  <= '0;
            s_sel  <= '1;
            s_dat0 <= '0;
            s_dat1 <= '0;
            cnt    <= '0;
            sh     <= '0;
            ev     <= '0;
            active <= 1'b0;
        end else begin
            s_clk  <= {s_clk[1:0], sclk};
            s_sel  <= {s_sel[0], sel_n};
            s_dat0 <= lane;
            s_dat1 <= s_dat0;
            active <= sel_live;
            ev.vld <= 1'b0;
            if (!sel_live) begin
                cnt <= '0;
                sh  <= '0;
            end else if (rise) begin
                if (cnt == LAST) begin
                    ev.vld <= 1'b1;
                    ev.val <= nxt;
                    cnt    <= '0;
                end else begin
                    sh  <= nxt;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    p_no_byte_unselected_r10: assert property (@(posedge clk) disable iff (rst)
        !sel_live |=> !ev.vld);

    p_byte_spacing_r11: assert property (@(posedge clk) disable iff (rst)
        ev.vld |=> !ev.vld);

endmodule

// File: rtl/hls_parser.sv
module hls_parser
    import hls_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  byte_ev_t          ev,
    input  logic              active,
    input  logic [ID_W-1:0]   my_id,
    output logic              wr_stb,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_stb,
    output logic [LEN_W-1:0]  rd_cnt,
    output logic              pass_stb
);
    pst_e              st;
    logic [2:0]        fn;
    logic [LEN_W-1:0]  remain;
    logic [ADDR_W-1:0] addr;
    logic [7:0]        b;

    assign b = ev.val;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= ST_CODE;
            fn       <= '0;
            remain   <= '0;
            addr     <= '0;
            wr_stb   <= 1'b0;
            wr_data  <= '0;
            reg_addr <= '0;
            rd_stb   <= 1'b0;
            rd_cnt   <= '0;
            pass_stb <= 1'b0;
        end else begin
            wr_stb   <= 1'b0;
            rd_stb   <= 1'b0;
            pass_stb <= 1'b0;
            if (!active) begin
                st <= ST_CODE;
            end else if (ev.vld) begin
                case (st)
                    ST_CODE: begin
                        fn     <= b[7:5];
                        remain <= LEN_W'(1);
                        addr   <= '0;
                        if (b[7:6] == 2'b11)       st <= ST_SKIP;
                        else if (b[7:5] == FN_BCW) st <= ST_LEN;
                        else                       st <= ST_ID;
                    end
                    ST_ID: begin
                        if (!id_hit(b[ID_W-1:0], my_id, fn == FN_PASS)) begin
                            st <= ST_SKIP;
                        end else if (fn == FN_PASS) begin
                            pass_stb <= 1'b1;
                            st       <= ST_SKIP;
                        end else if (fn_has_len(fn)) begin
                            st <= ST_LEN;
                        end else begin
                            st <= ST_ALO;
                        end
                    end
                    ST_LEN: begin
                        remain <= {1'b0, b} + LEN_W'(1);
                        st     <= (fn == FN_BCW) ? ST_AHI : ST_ALO;
                    end
                    ST_AHI: begin
                        addr[15:8] <= b;
                        st         <= ST_ALO;
                    end
                    ST_ALO: begin
                        addr[7:0] <= b;
                        if (fn_writes(fn)) begin
                            st <= ST_DATA;
                        end else begin
                            rd_stb   <= 1'b1;
                            reg_addr <= {addr[15:8], b};
                            rd_cnt   <= remain;
                            st       <= ST_SKIP;
                        end
                    end
                    ST_DATA: begin
                        wr_stb   <= 1'b1;
                        wr_data  <= b;
                        reg_addr <= addr;
                        addr     <= addr + 1'b1;
                        remain   <= remain - 1'b1;
                        if (remain == LEN_W'(1)) st <= ST_SKIP;
                    end
                    ST_SKIP: ;
                    default: st <= ST_CODE;
                endcase
            end
        end
    end

    // Helper for the address-increment check: last written address in this frame.
    logic [ADDR_W-1:0] chk_prev;
    logic              chk_ok;
    always_ff @(posedge clk) begin
        if (rst || !active || st == ST_CODE) begin
            chk_ok   <= 1'b0;
            chk_prev <= '0;
        end else if (wr_stb) begin
            chk_ok   <= 1'b1;
            chk_prev <= reg_addr;
        end
    end

    p_burst_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && chk_ok) |-> reg_addr == chk_prev + 16'd1);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_stb, rd_stb, pass_stb}));

    p_skip_silent_r6: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP && $past(st) == ST_SKIP) |-> !(wr_stb || rd_stb || pass_stb));

    p_abort_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !active |=> (st == ST_CODE && !wr_stb));

endmodule

// File: rtl/hls_rx.sv
module hls_rx
    import hls_pkg::*;
#(
    parameter int LANE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_sel_n,
    input  logic [LANE_W-1:0] spi_lane,
    input  logic [ID_W-1:0]   my_id,
    output logic              wr_stb,
    output logic [7:0]        wr_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              rd_stb,
    output logic [LEN_W-1:0]  rd_cnt,
    output logic              pass_stb
);
    byte_ev_t ev;
    logic     active;

    hls_frontend #(.LANE_W(LANE_W)) u_front (
        .clk    (clk),
        .rst    (rst),
        .sclk   (spi_sclk),
        .sel_n  (spi_sel_n),
        .lane   (spi_lane),
        .ev     (ev),
        .active (active)
    );

    hls_parser u_parse (
        .clk      (clk),
        .rst      (rst),
        .ev       (ev),
        .active   (active),
        .my_id    (my_id),
        .wr_stb   (wr_stb),
        .wr_data  (wr_data),
        .reg_addr (reg_addr),
        .rd_stb   (rd_stb),
        .rd_cnt   (rd_cnt),
        .pass_stb (pass_stb)
    );

    initial begin
        a_lane_width_r2: assert (LANE_W == 1 || LANE_W == 2 || LANE_W == 4 || LANE_W == 8);
    end

endmodule

// File: tb/tb_hls_rx.sv
`timescale 1ns/1ps
module tb_hls_rx;
    localparam int LW = 2;
    localparam int NB = 8 / LW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          sel_n = 1'b1;
    logic [LW-1:0] lane = '0;
    logic [3:0]    my_id = 4'h5;
    logic          wr_stb, rd_stb, pass_stb;
    logic [7:0]    wr_data;
    logic [15:0]   reg_addr;
    logic [8:0]    rd_cnt;

    always #2 clk = ~clk;

    hls_rx #(.LANE_W(LW)) dut (
        .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_sel_n(sel_n), .spi_lane(lane),
        .my_id(my_id), .wr_stb(wr_stb), .wr_data(wr_data), .reg_addr(reg_addr),
        .rd_stb(rd_stb), .rd_cnt(rd_cnt), .pass_stb(pass_stb)
    );

    int nchk = 0, nfail = 0;
    int wn = 0, rn = 0, pn = 0;
    logic [15:0] wa [0:1023];
    logic [7:0]  wd [0:1023];
    logic [15:0] ra;
    logic [8:0]  rc;
    bit done = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (wr_stb && wn < 1024) begin wa[wn] = reg_addr; wd[wn] = wr_data; wn++; end
            if (rd_stb) begin rn++; ra = reg_addr; rc = rd_cnt; end
            if (pass_stb) pn++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_beats(input logic [7:0] b, input int nb);
        for (int i = 0; i < nb; i++) begin
            lane = b[7 - i*LW -: LW];
            tick(3); sclk = 1'b1;
            tick(3); sclk = 1'b0;
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        send_beats(b, NB);
    endtask

    task automatic open_f;
        sel_n = 1'b0; tick(4);
    endtask

    task automatic close_f;
        tick(6); sel_n = 1'b1; tick(6);
    endtask

    task automatic expect_writes(input int base, input int n, input logic [15:0] a0,
                                 input logic [7:0] d0, input logic [7:0] step, input string req);
        check(wn - base == n, req, wn - base, n);
        if (wn - base == n)
            for (int i = 0; i < n; i++) begin
                check(wa[base+i] == a0 + 16'(i), req, wa[base+i], a0 + 16'(i));
                check(wd[base+i] == 8'(d0 + step*i), req, wd[base+i], 8'(d0 + step*i));
            end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        int base, r0, p0;
        tick(5);
        // R1: reset state
        check(!wr_stb && !rd_stb && !pass_stb, "R1 strobes", {wr_stb, rd_stb, pass_stb}, 0);
        check(reg_addr == 16'h0, "R1 addr", reg_addr, 0);
        rst = 1'b0; tick(5);

        // R3 / R6 / R2: single write, identifier sweep; low code-byte bits set to junk
        for (int id = 0; id < 16; id++) begin
            base = wn;
            open_f;
            send_byte(8'h1F & 8'(id));
            send_byte({4'hA, 4'(id)});
            send_byte(8'(id*16 + 3));
            send_byte(8'(id) ^ 8'hA5);
            close_f;
            if (id == 5 || id == 15)
                expect_writes(base, 1, 16'(id*16 + 3), 8'(id) ^ 8'hA5, 8'h0, "R3/R6/R2 match");
            else
                check(wn == base, "R6 no match", wn - base, 0);
        end

        // R4 / R11: burst write crossing into bit 8, L=3
        base = wn; open_f;
        send_byte(8'h20); send_byte(8'h05); send_byte(8'd3); send_byte(8'hFE);
        for (int i = 0; i < 4; i++) send_byte(8'(1 + 7*i));
        close_f;
        expect_writes(base, 4, 16'h00FE, 8'h01, 8'h07, "R4 burst L=3");

        // R4: longest burst L=255
        base = wn; open_f;
        send_byte(8'h20); send_byte(8'h0F); send_byte(8'd255); send_byte(8'h80);
        for (int i = 0; i < 256; i++) send_byte(8'(i));
        close_f;
        expect_writes(base, 256, 16'h0080, 8'h00, 8'h01, "R4 burst L=255");

        // R11: extra bytes beyond burst ignored
        base = wn; open_f;
        send_byte(8'h20); send_byte(8'h05); send_byte(8'd1); send_byte(8'h40);
        for (int i = 0; i < 5; i++) send_byte(8'(8'h60 + 2*i));
        close_f;
        expect_writes(base, 2, 16'h0040, 8'h60, 8'h02, "R11 overrun ignored");

        // R5: broadcast write with a non-matching my_id
        my_id = 4'h9;
        base = wn; open_f;
        send_byte(8'h80); send_byte(8'd2); send_byte(8'h12); send_byte(8'h34);
        for (int i = 0; i < 3; i++) send_byte(8'(8'hC0 + 3*i));
        close_f;
        expect_writes(base, 3, 16'h1234, 8'hC0, 8'h03, "R5 broadcast");
        my_id = 4'h5;

        // R7: single read, trailing bytes ignored
        base = wn; r0 = rn; open_f;
        send_byte(8'h40); send_byte(8'h05); send_byte(8'h4C);
        send_byte(8'h11); send_byte(8'h22);
        close_f;
        check(rn - r0 == 1, "R7 single rd count", rn - r0, 1);
        check(ra == 16'h004C, "R7 single rd addr", ra, 16'h004C);
        check(rc == 9'd1, "R7 single rd cnt", rc, 1);
        check(wn == base, "R7 no writes", wn - base, 0);

        // R7: burst read via all-ones identifier
        r0 = rn; open_f;
        send_byte(8'h60); send_byte(8'h0F); send_byte(8'd9); send_byte(8'hA0);
        close_f;
        check(rn - r0 == 1, "R7 burst rd count", rn - r0, 1);
        check(ra == 16'h00A0, "R7 burst rd addr", ra, 16'h00A0);
        check(rc == 9'd10, "R7 burst rd cnt", rc, 10);

        // R8: mastership transfer: exact id, all-ones, other id
        p0 = pn; open_f; send_byte(8'hA0); send_byte(8'h05); close_f;
        check(pn - p0 == 1, "R8 exact id", pn - p0, 1);
        p0 = pn; open_f; send_byte(8'hA0); send_byte(8'h0F); close_f;
        check(pn - p0 == 0, "R8 all-ones", pn - p0, 0);
        p0 = pn; open_f; send_byte(8'hA0); send_byte(8'h03); close_f;
        check(pn - p0 == 0, "R8 other id", pn - p0, 0);

        // R9: reserved codes
        for (int c = 6; c < 8; c++) begin
            base = wn; r0 = rn; p0 = pn; open_f;
            send_byte(8'(c << 5)); send_byte(8'h05); send_byte(8'h10); send_byte(8'hAA);
            send_byte(8'h40); send_byte(8'hA0); send_byte(8'h05);
            close_f;
            check(wn == base && rn == r0 && pn == p0, "R9 reserved silent",
                  (wn - base) + (rn - r0) + (pn - p0), 0);
        end
        base = wn; open_f;
        send_byte(8'h00); send_byte(8'h05); send_byte(8'h33); send_byte(8'h44);
        close_f;
        expect_writes(base, 1, 16'h0033, 8'h44, 8'h00, "R9 recovery");

        // R10: abort mid-byte inside a burst, then a clean single write
        base = wn; open_f;
        send_byte(8'h20); send_byte(8'h05); send_byte(8'd5); send_byte(8'h10);
        send_byte(8'h91); send_byte(8'h92);
        send_beats(8'hFF, NB/2);
        close_f;
        expect_writes(base, 2, 16'h0010, 8'h91, 8'h01, "R10 abort keeps whole bytes");
        base = wn; open_f;
        send_byte(8'h00); send_byte(8'h05); send_byte(8'h77); send_byte(8'h3C);
        close_f;
        expect_writes(base, 1, 16'h0077, 8'h3C, 8'h00, "R10 next frame clean");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule